// File: doc/BRIEF.md
# Programmable Raster Sync Generator

This block drives the scan timing of one display pipe. Two free-running counters step on the pixel clock and give the horizontal position (X) and the line number (Y). The sizes of the active area and the full frame, and a start/end window for each sync signal, come from a small register port. From these the block drives horizontal and vertical sync, a data-enable that marks the visible area, and a one-cycle pulse when the frame leaves its last visible line.

Software can read the live scan position and a running count of vertical blanks at any time. It can also arm an interrupt on the leading edge of either sync window. Event status bits stay set until software clears them. Register writes take effect at the next clock edge. The counters use the timing values held before that edge, so a new setting applies from the following cycle.

Top module: `scan_timing_gen`

## Requirements
- R1: While reset is held, all registers and both counters are zero. hsync, vsync, de, vblank and irq are low, and every read address returns 0.
- R2: X steps by one per clock and returns to 0 on the cycle after it reaches H total minus 1. If H total is 0 or 1, or X is already at or above H total (for example after H total is lowered), X returns to 0 on the next cycle.
- R3: Y changes only in a cycle where X wraps. Y steps by one, and returns to 0 when it reaches V total minus 1 or is already at or above V total.
- R4: HSYNC word (address 2): start in bits 12:0, end in bits 28:16, enable in bit 30, invert in bit 31. hsync equals invert XOR (enable AND start <= X < end).
- R5: VSYNC word (address 3): start in bits 11:0, end in bits 27:16, enable in bit 30, invert in bit 31. vsync equals invert XOR (enable AND start <= Y < end).
- R6: Size words: address 0 holds H active in bits 12:0 and H total in bits 28:16. Address 1 holds V active in bits 11:0 and V total in bits 27:16. de is high exactly when X < H active and Y < V active.
- R7: vblank is high for exactly the first cycle in which Y equals a nonzero V active, reached through a horizontal wrap.
- R8: The vblank count (address 6, 32 bits) resets to 0. It increases by one in the same cycle in which vblank is high.
- R9: Address 5 returns the scan position, with X in bits 31:16 and Y in bits 15:0.
- R10: Interrupt word (address 4). Status bit 0 records a rise of the gated horizontal window (enable AND start <= X < end), and status bit 1 records a rise of the gated vertical window. Each status bit is set one cycle after its window rises and then stays set. Writing 1 to a status bit clears it, and a new rise in the same cycle wins over the clear. Bits 17:16 are the matching enables, loaded directly by a write.
- R11: irq is high exactly when some status bit and its enable are both set.
- R12: Writes to addresses 5, 6 and 7 change nothing. Reading addresses 0 to 4 returns the stored fields, with all undefined bits read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 3 | Register read address |
| rd_data | output | 32 | Read data for rd_addr, combinational |
| hsync | output | 1 | Horizontal sync |
| vsync | output | 1 | Vertical sync |
| de | output | 1 | Data enable, visible area |
| vblank | output | 1 | One-cycle pulse at start of vertical blank |
| irq | output | 1 | Interrupt request |

## Verification
On every cycle, the assertions check these properties:
- the horizontal wrap, including wrapping out of range after H total is reduced;
- that the line counter holds between wraps;
- that the vblank pulse lasts a single cycle and moves the vblank count by exactly one;
- that status bits stay set unless cleared;
- that writes to read-only addresses leave the configuration alone.

Some behaviour only the bench scenarios can show. This covers the exact sync and data-enable waveforms under changing windows and polarities, and the placement of the vblank pulse. It also covers the field layout of every readback word, and the case where a window rise and a clear write land in the same cycle. The bench shows these by comparing the outputs each cycle with a reference model built from the requirements. Random timings are reprogrammed while the counters run.

// File: rtl/scan_timing_pkg.sv
package scan_timing_pkg;

    localparam int H_BITS_DEF   = 13;
    localparam int V_BITS_DEF   = 12;
    localparam int CNT_BITS_DEF = 32;
    localparam int EVT_NUM      = 2;

    // Field placement inside the 32-bit register words
    localparam int LO_LSB  = 0;
    localparam int HI_LSB  = 16;
    localparam int EN_BIT  = 30;
    localparam int INV_BIT = 31;

    typedef enum logic [2:0] {
        ADDR_HSIZE = 3'd0,
        ADDR_VSIZE = 3'd1,
        ADDR_HSYNC = 3'd2,
        ADDR_VSYNC = 3'd3,
        ADDR_IRQ   = 3'd4,
        ADDR_SCAN  = 3'd5,
        ADDR_VBCNT = 3'd6,
        ADDR_SPARE = 3'd7
    } reg_addr_e;

endpackage

// File: rtl/scan_timing_window.sv
module scan_timing_window #(
    parameter int W = 13
) (
    input  logic [W-1:0] pos,
    input  logic [W-1:0] start,
    input  logic [W-1:0] stop,
    input  logic         enable,
    input  logic         invert,
    output logic         active,
    output logic         sync_o
);

    always_comb begin
        active = enable && (pos >= start) && (pos < stop);
        sync_o = invert ^ active;
    end

endmodule

// File: rtl/scan_timing_counters.sv
module scan_timing_counters #(
    parameter int HW = 13,
    parameter int VW = 12,
    parameter int CW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [HW-1:0] h_active,
    input  logic [HW-1:0] h_total,
    input  logic [VW-1:0] v_active,
    input  logic [VW-1:0] v_total,
    output logic [HW-1:0] h_pos,
    output logic [VW-1:0] v_pos,
    output logic          de,
    output logic          vbl_pulse,
    output logic [CW-1:0] vbl_count
);

    typedef struct packed {
        logic [HW-1:0] h;
        logic [VW-1:0] v;
        logic          vbl;
        logic [CW-1:0] cnt;
    } ctr_t;

    ctr_t ctr_d, ctr_q;
    logic h_wrap, v_wrap;

    always_comb begin
        h_wrap = ({1'b0, ctr_q.h} + (HW+1)'(1)) >= {1'b0, h_total};
        v_wrap = ({1'b0, ctr_q.v} + (VW+1)'(1)) >= {1'b0, v_total};
        ctr_d     = ctr_q;
        ctr_d.vbl = 1'b0;
        if (h_wrap) begin
            ctr_d.h = '0;
            ctr_d.v = v_wrap ? '0 : ctr_q.v + VW'(1);
            ctr_d.vbl = (v_active != '0) && (ctr_d.v == v_active);
        end else begin
            ctr_d.h = ctr_q.h + HW'(1);
        end
        if (ctr_d.vbl) ctr_d.cnt = ctr_q.cnt + CW'(1);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ctr_q <= '0;
        else        ctr_q <= ctr_d;
    end

    assign h_pos     = ctr_q.h;
    assign v_pos     = ctr_q.v;
    assign vbl_pulse = ctr_q.vbl;
    assign vbl_count = ctr_q.cnt;
    assign de        = (ctr_q.h < h_active) && (ctr_q.v < v_active);

    assert_h_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (({1'b0, h_pos} + (HW+1)'(1)) >= {1'b0, h_total}) |=> (h_pos == '0));

    assert_v_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !h_wrap |=> $stable(v_pos));

    assert_vbl_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        vbl_pulse |=> !vbl_pulse);

    assert_vbl_count_R8: assert property (@(posedge clk) disable iff (!rst_n)
        vbl_pulse |-> (vbl_count == $past(vbl_count) + CW'(1)));

endmodule

// File: rtl/scan_timing_irq.sv
module scan_timing_irq #(
    parameter int NI = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NI-1:0] src,
    input  logic          irq_we,
    input  logic [NI-1:0] clr_mask,
    input  logic [NI-1:0] en_val,
    output logic [NI-1:0] status,
    output logic [NI-1:0] enable,
    output logic          irq
);

    typedef struct packed {
        logic [NI-1:0] sts;
        logic [NI-1:0] en;
        logic [NI-1:0] prev;
    } irq_t;

    irq_t irq_d, irq_q;

    always_comb begin
        irq_d      = irq_q;
        irq_d.prev = src;
        irq_d.sts  = (irq_q.sts & ~(irq_we ? clr_mask : '0)) | (src & ~irq_q.prev);
        if (irq_we) irq_d.en = en_val;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) irq_q <= '0;
        else        irq_q <= irq_d;
    end

    assign status = irq_q.sts;
    assign enable = irq_q.en;
    assign irq    = |(irq_q.sts & irq_q.en);

    for (genvar i = 0; i < NI; i++) begin : g_sticky
        assert_sts_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
            (status[i] && !(irq_we && clr_mask[i])) |=> status[i]);
    end

endmodule

// File: rtl/scan_timing_regs.sv
module scan_timing_regs
    import scan_timing_pkg::*;
#(
    parameter int HW = 13,
    parameter int VW = 12,
    parameter int NI = 2,
    parameter int CW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [2:0]    wr_addr,
    input  logic [31:0]   wr_data,
    input  logic [2:0]    rd_addr,
    output logic [31:0]   rd_data,
    input  logic [HW-1:0] h_pos,
    input  logic [VW-1:0] v_pos,
    input  logic [NI-1:0] irq_status,
    input  logic [NI-1:0] irq_enable,
    input  logic [CW-1:0] vbl_count,
    output logic          irq_we,
    output logic [HW-1:0] h_active,
    output logic [HW-1:0] h_total,
    output logic [VW-1:0] v_active,
    output logic [VW-1:0] v_total,
    output logic [HW-1:0] hs_start,
    output logic [HW-1:0] hs_stop,
    output logic          hs_en,
    output logic          hs_inv,
    output logic [VW-1:0] vs_start,
    output logic [VW-1:0] vs_stop,
    output logic          vs_en,
    output logic          vs_inv
);

    typedef struct packed {
        logic [HW-1:0] h_act;
        logic [HW-1:0] h_tot;
        logic [VW-1:0] v_act;
        logic [VW-1:0] v_tot;
        logic [HW-1:0] hs_st;
        logic [HW-1:0] hs_sp;
        logic          hs_e;
        logic          hs_i;
        logic [VW-1:0] vs_st;
        logic [VW-1:0] vs_sp;
        logic          vs_e;
        logic          vs_i;
    } cfg_t;

    cfg_t cfg_d, cfg_q;
    logic unused_wr;

    assign unused_wr = ^wr_data;

    always_comb begin
        cfg_d = cfg_q;
        if (wr_en) begin
            case (reg_addr_e'(wr_addr))
                ADDR_HSIZE: begin
                    cfg_d.h_act = wr_data[LO_LSB +: HW];
                    cfg_d.h_tot = wr_data[HI_LSB +: HW];
                end
                ADDR_VSIZE: begin
                    cfg_d.v_act = wr_data[LO_LSB +: VW];
                    cfg_d.v_tot = wr_data[HI_LSB +: VW];
                end
                ADDR_HSYNC: begin
                    cfg_d.hs_st = wr_data[LO_LSB +: HW];
                    cfg_d.hs_sp = wr_data[HI_LSB +: HW];
                    cfg_d.hs_e  = wr_data[EN_BIT];
                    cfg_d.hs_i  = wr_data[INV_BIT];
                end
                ADDR_VSYNC: begin
                    cfg_d.vs_st = wr_data[LO_LSB +: VW];
                    cfg_d.vs_sp = wr_data[HI_LSB +: VW];
                    cfg_d.vs_e  = wr_data[EN_BIT];
                    cfg_d.vs_i  = wr_data[INV_BIT];
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    always_comb begin
        rd_data = '0;
        case (reg_addr_e'(rd_addr))
            ADDR_HSIZE: begin
                rd_data[LO_LSB +: HW] = cfg_q.h_act;
                rd_data[HI_LSB +: HW] = cfg_q.h_tot;
            end
            ADDR_VSIZE: begin
                rd_data[LO_LSB +: VW] = cfg_q.v_act;
                rd_data[HI_LSB +: VW] = cfg_q.v_tot;
            end
            ADDR_HSYNC: begin
                rd_data[LO_LSB +: HW] = cfg_q.hs_st;
                rd_data[HI_LSB +: HW] = cfg_q.hs_sp;
                rd_data[EN_BIT]       = cfg_q.hs_e;
                rd_data[INV_BIT]      = cfg_q.hs_i;
            end
            ADDR_VSYNC: begin
                rd_data[LO_LSB +: VW] = cfg_q.vs_st;
                rd_data[HI_LSB +: VW] = cfg_q.vs_sp;
                rd_data[EN_BIT]       = cfg_q.vs_e;
                rd_data[INV_BIT]      = cfg_q.vs_i;
            end
            ADDR_IRQ: begin
                rd_data[LO_LSB +: NI] = irq_status;
                rd_data[HI_LSB +: NI] = irq_enable;
            end
            ADDR_SCAN: begin
                rd_data[HI_LSB +: HW] = h_pos;
                rd_data[LO_LSB +: VW] = v_pos;
            end
            ADDR_VBCNT: rd_data[CW-1:0] = vbl_count;
            default: ;
        endcase
    end

    assign irq_we   = wr_en && (wr_addr == ADDR_IRQ);
    assign h_active = cfg_q.h_act;
    assign h_total  = cfg_q.h_tot;
    assign v_active = cfg_q.v_act;
    assign v_total  = cfg_q.v_tot;
    assign hs_start = cfg_q.hs_st;
    assign hs_stop  = cfg_q.hs_sp;
    assign hs_en    = cfg_q.hs_e;
    assign hs_inv   = cfg_q.hs_i;
    assign vs_start = cfg_q.vs_st;
    assign vs_stop  = cfg_q.vs_sp;
    assign vs_en    = cfg_q.vs_e;
    assign vs_inv   = cfg_q.vs_i;

    assert_ro_ignored_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (wr_addr >= ADDR_SCAN)) |=> $stable(cfg_q));

endmodule

// File: rtl/scan_timing_gen.sv
module scan_timing_gen
    import scan_timing_pkg::*;
#(
    parameter int HW = H_BITS_DEF,
    parameter int VW = V_BITS_DEF,
    parameter int CW = CNT_BITS_DEF
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [2:0]  wr_addr,
    input  logic [31:0] wr_data,
    input  logic [2:0]  rd_addr,
    output logic [31:0] rd_data,
    output logic        hsync,
    output logic        vsync,
    output logic        de,
    output logic        vblank,
    output logic        irq
);

    localparam int NI = EVT_NUM;

    logic [HW-1:0] h_active, h_total, hs_start, hs_stop, h_pos;
    logic [VW-1:0] v_active, v_total, vs_start, vs_stop, v_pos;
    logic          hs_en, hs_inv, vs_en, vs_inv, irq_we;
    logic          h_win, v_win;
    logic [NI-1:0] irq_status, irq_enable;
    logic [CW-1:0] vbl_count;

    scan_timing_regs #(.HW(HW), .VW(VW), .NI(NI), .CW(CW)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .rd_addr    (rd_addr),
        .rd_data    (rd_data),
        .h_pos      (h_pos),
        .v_pos      (v_pos),
        .irq_status (irq_status),
        .irq_enable (irq_enable),
        .vbl_count  (vbl_count),
        .irq_we     (irq_we),
        .h_active   (h_active),
        .h_total    (h_total),
        .v_active   (v_active),
        .v_total    (v_total),
        .hs_start   (hs_start),
        .hs_stop    (hs_stop),
        .hs_en      (hs_en),
        .hs_inv     (hs_inv),
        .vs_start   (vs_start),
        .vs_stop    (vs_stop),
        .vs_en      (vs_en),
        .vs_inv     (vs_inv)
    );

    scan_timing_counters #(.HW(HW), .VW(VW), .CW(CW)) u_ctr (
        .clk       (clk),
        .rst_n     (rst_n),
        .h_active  (h_active),
        .h_total   (h_total),
        .v_active  (v_active),
        .v_total   (v_total),
        .h_pos     (h_pos),
        .v_pos     (v_pos),
        .de        (de),
        .vbl_pulse (vblank),
        .vbl_count (vbl_count)
    );

    scan_timing_window #(.W(HW)) u_hwin (
        .pos    (h_pos),
        .start  (hs_start),
        .stop   (hs_stop),
        .enable (hs_en),
        .invert (hs_inv),
        .active (h_win),
        .sync_o (hsync)
    );

    scan_timing_window #(.W(VW)) u_vwin (
        .pos    (v_pos),
        .start  (vs_start),
        .stop   (vs_stop),
        .enable (vs_en),
        .invert (vs_inv),
        .active (v_win),
        .sync_o (vsync)
    );

    scan_timing_irq #(.NI(NI)) u_irq (
        .clk      (clk),
        .rst_n    (rst_n),
        .src      ({v_win, h_win}),
        .irq_we   (irq_we),
        .clr_mask (wr_data[LO_LSB +: NI]),
        .en_val   (wr_data[HI_LSB +: NI]),
        .status   (irq_status),
        .enable   (irq_enable),
        .irq      (irq)
    );

endmodule

// File: tb/scan_timing_gen_tb.sv
module scan_timing_gen_tb;

    localparam int HW = 13;
    localparam int VW = 12;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [2:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic        hsync, vsync, de, vblank, irq;

    int n_chk = 0;
    int n_bad = 0;
    logic chk_on = 1'b0;

    always #4 clk = ~clk;

    scan_timing_gen u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .hsync(hsync), .vsync(vsync), .de(de), .vblank(vblank), .irq(irq)
    );

    // Reference model state
    logic [HW-1:0] m_hact, m_htot, m_hss, m_hse, m_hc;
    logic [VW-1:0] m_vact, m_vtot, m_vss, m_vse, m_vc;
    logic          m_hsen, m_hsinv, m_vsen, m_vsinv, m_vbl;
    logic [1:0]    m_sts, m_ien, m_prev;
    logic [31:0]   m_cnt;

    function automatic logic hwin();
        return m_hsen && (m_hc >= m_hss) && (m_hc < m_hse);
    endfunction

    function automatic logic vwin();
        return m_vsen && (m_vc >= m_vss) && (m_vc < m_vse);
    endfunction

    function automatic logic [31:0] exp_rd(input logic [2:0] a);
        logic [31:0] r;
        r = '0;
        case (a)
            3'd0: begin r[12:0] = m_hact; r[28:16] = m_htot; end
            3'd1: begin r[11:0] = m_vact; r[27:16] = m_vtot; end
            3'd2: begin r[12:0] = m_hss; r[28:16] = m_hse; r[30] = m_hsen; r[31] = m_hsinv; end
            3'd3: begin r[11:0] = m_vss; r[27:16] = m_vse; r[30] = m_vsen; r[31] = m_vsinv; end
            3'd4: begin r[1:0] = m_sts; r[17:16] = m_ien; end
            3'd5: begin r[28:16] = m_hc; r[11:0] = m_vc; end
            3'd6: r = m_cnt;
            default: r = '0;
        endcase
        return r;
    endfunction

    always @(posedge clk) begin : model
        logic hw, vw, vb;
        logic [VW-1:0] vnext;
        logic [1:0] win, clr;
        if (!rst_n) begin
            m_hact <= '0; m_htot <= '0; m_hss <= '0; m_hse <= '0; m_hc <= '0;
            m_vact <= '0; m_vtot <= '0; m_vss <= '0; m_vse <= '0; m_vc <= '0;
            m_hsen <= 1'b0; m_hsinv <= 1'b0; m_vsen <= 1'b0; m_vsinv <= 1'b0;
            m_vbl <= 1'b0; m_sts <= '0; m_ien <= '0; m_prev <= '0; m_cnt <= '0;
        end else begin
            hw = ({1'b0, m_hc} + 14'd1) >= {1'b0, m_htot};
            vw = ({1'b0, m_vc} + 13'd1) >= {1'b0, m_vtot};
            vb = 1'b0;
            if (hw) begin
                m_hc <= '0;
                vnext = vw ? '0 : m_vc + 12'd1;
                m_vc <= vnext;
                vb = (m_vact != '0) && (vnext == m_vact);
            end else begin
                m_hc <= m_hc + 13'd1;
            end
            m_vbl <= vb;
            if (vb) m_cnt <= m_cnt + 32'd1;
            win = {vwin(), hwin()};
            clr = (wr_en && wr_addr == 3'd4) ? wr_data[1:0] : 2'b00;
            m_sts  <= (m_sts & ~clr) | (win & ~m_prev);
            m_prev <= win;
            if (wr_en) begin
                case (wr_addr)
                    3'd0: begin m_hact <= wr_data[12:0]; m_htot <= wr_data[28:16]; end
                    3'd1: begin m_vact <= wr_data[11:0]; m_vtot <= wr_data[27:16]; end
                    3'd2: begin m_hss <= wr_data[12:0]; m_hse <= wr_data[28:16];
                                m_hsen <= wr_data[30]; m_hsinv <= wr_data[31]; end
                    3'd3: begin m_vss <= wr_data[11:0]; m_vse <= wr_data[27:16];
                                m_vsen <= wr_data[30]; m_vsinv <= wr_data[31]; end
                    3'd4: m_ien <= wr_data[17:16];
                    default: ;
                endcase
            end
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // Per-cycle comparison against the model, away from the active edge
    always @(negedge clk) begin
        if (rst_n && chk_on) begin
            chk("R4 hsync", {31'd0, hsync}, {31'd0, m_hsinv ^ hwin()});
            chk("R5 vsync", {31'd0, vsync}, {31'd0, m_vsinv ^ vwin()});
            chk("R6 de", {31'd0, de}, {31'd0, (m_hc < m_hact) && (m_vc < m_vact)});
            chk("R7 vblank", {31'd0, vblank}, {31'd0, m_vbl});
            chk("R11 irq", {31'd0, irq}, {31'd0, |(m_sts & m_ien)});
            case (rd_addr)
                3'd4: chk("R10 irq word", rd_data, exp_rd(rd_addr));
                3'd5: begin
                    chk("R2 x position", {16'd0, rd_data[31:16]}, {19'd0, m_hc});
                    chk("R3 y position", {16'd0, rd_data[15:0]}, {20'd0, m_vc});
                    chk("R9 scan word", rd_data, exp_rd(rd_addr));
                end
                3'd6: chk("R8 vblank count", rd_data, m_cnt);
                default: chk("R12 readback", rd_data, exp_rd(rd_addr));
            endcase
        end
    end

    task automatic step();
        @(posedge clk);
        #1;
        wr_en = 1'b0;
        rd_addr = 3'($urandom % 8);
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(posedge clk);
        #1;
        wr_en = 1'b1;
        wr_addr = a;
        wr_data = d;
        rd_addr = 3'($urandom % 8);
    endtask

    function automatic logic [31:0] rand_data(input logic [2:0] a);
        int unsigned tot, act, st, sp, fl;
        if ($urandom % 8 == 0) return $urandom;
        case (a)
            3'd0, 3'd1: begin
                tot = 1 + $urandom % 16;
                act = $urandom % (tot + 2);
                return (tot << 16) | act;
            end
            3'd2, 3'd3: begin
                st = $urandom % 18;
                sp = $urandom % 18;
                fl = $urandom % 4;
                return (fl << 30) | (sp << 16) | st;
            end
            default: return $urandom;
        endcase
    endfunction

    initial begin
        repeat (2000000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        // R1: reset state
        repeat (3) @(posedge clk);
        #1;
        for (int a = 0; a < 8; a++) begin
            rd_addr = 3'(a);
            #1;
            chk("R1 reset read", rd_data, 32'd0);
        end
        chk("R1 reset outputs", {27'd0, hsync, vsync, de, vblank, irq}, 32'd0);
        @(negedge clk);
        rst_n = 1'b1;
        chk_on = 1'b1;

        // Directed frame: 10x6 total, 6x4 active, active-low vsync
        wr(3'd0, (32'd10 << 16) | 32'd6);
        wr(3'd1, (32'd6 << 16) | 32'd4);
        wr(3'd2, (32'h1 << 30) | (32'd9 << 16) | 32'd7);
        wr(3'd3, (32'h3 << 30) | (32'd5 << 16) | 32'd4);
        wr(3'd4, 32'h0003_0000);
        repeat (300) step();

        // R12: writes to read-only addresses are ignored
        wr(3'd5, 32'hFFFF_FFFF);
        wr(3'd6, 32'hFFFF_FFFF);
        wr(3'd7, 32'hFFFF_FFFF);
        step();
        for (int a = 0; a < 4; a++) begin
            rd_addr = 3'(a);
            #1;
            chk("R12 ro write ignored", rd_data, exp_rd(3'(a)));
        end

        // R10: clear sticky status with windows disabled
        wr(3'd2, 32'd0);
        wr(3'd3, 32'd0);
        repeat (3) step();
        wr(3'd4, 32'h0003_0003);
        step();
        rd_addr = 3'd4;
        #1;
        chk("R10 status cleared", rd_data, 32'h0003_0000);
        chk("R11 irq low after clear", {31'd0, irq}, 32'd0);

        // R2: lower H total below current X
        wr(3'd0, (32'd200 << 16) | 32'd100);
        repeat (150) step();
        wr(3'd0, (32'd5 << 16) | 32'd3);
        repeat (20) step();

        // Random reprogramming while running
        for (int i = 0; i < 20000; i++) begin
            if ($urandom % 40 == 0) begin
                automatic logic [2:0] a = 3'($urandom % 8);
                wr(a, rand_data(a));
            end else begin
                step();
            end
        end
        repeat (5) step();
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule